// File: doc/BRIEF.md
# TDM Slot-Mapped Serial Transmitter

This block sends up to four parallel audio samples as one serial stream inside a time-division frame of 48 eight-bit slots. Each channel has its own start-slot setting and its own "data missing" flag. A 48-bit drive mask decides, slot by slot, whether the serial pin is actively driven or released to high impedance. A tri-state pad outside the block takes the data bit and its output enable.

The block runs on the bit clock. A one-cycle frame-sync pulse starts each frame. On that pulse the block captures the channel samples and all mapping settings, so a frame is built entirely from one coherent snapshot. It then shifts out 384 bit periods, MSB first. When a channel's 24-bit sample would run past slot 47, the part that does not fit is dropped. When two channels claim the same slot, the lower channel index wins.

Top module: `tdm_slot_tx`

## Requirements
- R1: A bit-clock cycle with `frameSync` high starts a frame. Slot 0 bit 7 appears on `sdOut` in the cycle after that edge, and each following cycle advances one bit. After 384 bits with no new pulse, `sdOe` goes low until the next pulse. A pulse that arrives mid-frame restarts at slot 0.
- R2: Slots are 8 bits wide and sent from bit 7 down to bit 0. A 24-bit sample with start code s fills slots s, s+1 and s+2 with sample bits [23:16], [15:8] and [7:0] respectively.
- R3: A start code from 48 to 63 places none of that channel's data in any slot.
- R4: A channel whose `chNotAvail` bit is 1 places no data in any slot.
- R5: Mask bit n (`slotEnable[n]`) set to 1 drives `sdOe` high for all 8 bits of slot n. Set to 0, it holds `sdOe` low for that slot. Whenever `sdOe` is low, `sdOut` is 0.
- R6: An enabled slot that no available channel claims is sent as all zeros.
- R7: When several channels claim one slot, the channel with the lowest index supplies its bits.
- R8: Sample bits that would fall after slot 47 are not sent, and the frame still ends after slot 47.
- R9: Samples, start codes, flags and mask are captured only in the frame-sync cycle. Changes during a frame have no effect until the next frame.
- R10: While `rstN` is low, and afterwards until the first frame-sync pulse, `sdOe` and `sdOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | One-cycle frame start pulse |
| chSample | input | 96 | Channel c sample at bits [c*24 +: 24] |
| chStart | input | 24 | Channel c start-slot code at bits [c*6 +: 6] |
| chNotAvail | input | 4 | Bit c = 1 marks channel c as having no data |
| slotEnable | input | 48 | Bit n = 1 drives the pin during slot n |
| sdOut | output | 1 | Serial data bit |
| sdOe | output | 1 | Output enable for the tri-state pad |

## Verification
The first pattern walks channel 0 across every start code from 0 to 47 while the other channels are parked on reserved codes. This separates correct slot placement and bit order from truncation at the frame end. Fixed patterns then isolate single behaviours: deliberate overlaps, which expose the priority order; reserved codes and missing-data flags, which must leave zero-filled driven slots; and sparse masks, which separate the enable path from the data path. Random frames mix all settings. One frame changes every input right after the sync pulse to show the snapshot holds, and a truncated frame shows the restart and the idle state after a full frame.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int NUM_SLOTS  = 48;
  localparam int SLOT_W     = 8;
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
  localparam int BIT_IDX_W  = $clog2(SLOT_W);
  localparam int FRAME_BITS = NUM_SLOTS * SLOT_W;

  // strobes and position from control to datapath
  typedef struct packed {
    logic                  load;
    logic                  active;
    logic [SLOT_IDX_W-1:0] slot;
    logic [BIT_IDX_W-1:0]  bitPos;
  } tdmCtrlT;
endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_slot_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameSync,
  output tdmCtrlT ctrl
);
  logic                  activeQ;
  logic [SLOT_IDX_W-1:0] slotQ;
  logic [BIT_IDX_W-1:0]  bitQ;
  logic                  slotDone;
  logic                  frameDone;

  assign slotDone  = (bitQ == BIT_IDX_W'(SLOT_W - 1));
  assign frameDone = slotDone && (slotQ == SLOT_IDX_W'(NUM_SLOTS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      slotQ   <= '0;
      bitQ    <= '0;
    end else if (frameSync) begin
      activeQ <= 1'b1;
      slotQ   <= '0;
      bitQ    <= '0;
    end else if (activeQ) begin
      if (frameDone) begin
        activeQ <= 1'b0;
        slotQ   <= '0;
        bitQ    <= '0;
      end else if (slotDone) begin
        bitQ  <= '0;
        slotQ <= slotQ + 1'b1;
      end else begin
        bitQ <= bitQ + 1'b1;
      end
    end
  end

  always_comb begin
    ctrl.load   = frameSync;
    ctrl.active = activeQ;
    ctrl.slot   = slotQ;
    ctrl.bitPos = bitQ;
  end
endmodule

// File: rtl/tdm_slot_dp.sv
module tdm_slot_dp
  import tdm_slot_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  tdmCtrlT                      ctrl,
  input  logic [NUM_CH*SAMPLE_W-1:0]   chSample,
  input  logic [NUM_CH*SLOT_IDX_W-1:0] chStart,
  input  logic [NUM_CH-1:0]            chNotAvail,
  input  logic [NUM_SLOTS-1:0]         slotEnable,
  output logic                         sdOut,
  output logic                         sdOe
);
  localparam int SPAN  = (SAMPLE_W + SLOT_W - 1) / SLOT_W;
  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0]   sampleQ [NUM_CH];
  logic [SLOT_IDX_W-1:0] startQ  [NUM_CH];
  logic [NUM_CH-1:0]     naQ;
  logic [NUM_SLOTS-1:0]  maskQ;
  logic [NUM_CH-1:0]     hit;
  logic [NUM_CH-1:0]     bitVal;
  logic                  anyHit;
  logic                  selBit;

  // snapshot of the whole mapping at frame start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        sampleQ[c] <= '0;
        startQ[c]  <= SLOT_IDX_W'(NUM_SLOTS - 1);
      end
      naQ   <= '0;
      maskQ <= '0;
    end else if (ctrl.load) begin
      for (int c = 0; c < NUM_CH; c++) begin
        sampleQ[c] <= chSample[c*SAMPLE_W +: SAMPLE_W];
        startQ[c]  <= chStart[c*SLOT_IDX_W +: SLOT_IDX_W];
      end
      naQ   <= chNotAvail;
      maskQ <= slotEnable;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      int rel;
      int pos;
      rel       = int'(ctrl.slot) - int'(startQ[c]);
      pos       = rel * SLOT_W + int'(ctrl.bitPos);
      hit[c]    = !naQ[c] && (int'(startQ[c]) < NUM_SLOTS) &&
                  (rel >= 0) && (rel < SPAN) && (pos < SAMPLE_W);
      bitVal[c] = 1'b0;
      if (hit[c]) bitVal[c] = sampleQ[c][IDX_W'(SAMPLE_W - 1 - pos)];
    end
  end

  // lowest index claims the slot
  always_comb begin
    anyHit = 1'b0;
    selBit = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (hit[c]) begin
        anyHit = 1'b1;
        selBit = bitVal[c];
      end
    end
  end

  always_comb begin
    sdOe  = ctrl.active && maskQ[ctrl.slot];
    sdOut = sdOe && anyHit && selBit;
  end
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_slot_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         frameSync,
  input  logic [NUM_CH*SAMPLE_W-1:0]   chSample,
  input  logic [NUM_CH*SLOT_IDX_W-1:0] chStart,
  input  logic [NUM_CH-1:0]            chNotAvail,
  input  logic [NUM_SLOTS-1:0]         slotEnable,
  output logic                         sdOut,
  output logic                         sdOe
);
  tdmCtrlT ctrl;

  tdm_slot_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .ctrl      (ctrl)
  );

  tdm_slot_dp #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .chSample   (chSample),
    .chStart    (chStart),
    .chNotAvail (chNotAvail),
    .slotEnable (slotEnable),
    .sdOut      (sdOut),
    .sdOe       (sdOe)
  );
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk
  import tdm_slot_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    frameSync,
  input logic    sdOut,
  input logic    sdOe,
  input tdmCtrlT ctrl
);
  // R1
  frame_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> ctrl.active && ctrl.slot == '0 && ctrl.bitPos == '0);

  // R1
  frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active && !frameSync && ctrl.slot == SLOT_IDX_W'(NUM_SLOTS - 1) &&
    ctrl.bitPos == BIT_IDX_W'(SLOT_W - 1) |=> !ctrl.active);

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active && !frameSync && ctrl.bitPos != BIT_IDX_W'(SLOT_W - 1) |=>
    ctrl.bitPos == BIT_IDX_W'($past(ctrl.bitPos) + 1) && $stable(ctrl.slot));

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active && !frameSync && ctrl.bitPos == BIT_IDX_W'(SLOT_W - 1) &&
    ctrl.slot != SLOT_IDX_W'(NUM_SLOTS - 1) |=>
    ctrl.slot == SLOT_IDX_W'($past(ctrl.slot) + 1) && ctrl.bitPos == '0);

  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdOe |-> !sdOut);

  // R10
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.active |-> !sdOe);
endmodule

bind tdm_slot_tx tdm_slot_tx_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .frameSync (frameSync),
  .sdOut     (sdOut),
  .sdOe      (sdOe),
  .ctrl      (ctrl)
);

// File: tb/tdm_slot_tx_tb.sv
module tdm_slot_tx_tb_top;
  localparam int NCH = 4;
  localparam int SW  = 24;
  localparam int NS  = 48;
  localparam int BW  = 8;
  localparam int FB  = NS * BW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN;
  logic              frameSync;
  logic [NCH*SW-1:0] sampleBus;
  logic [NCH*6-1:0]  startBus;
  logic [NCH-1:0]    naBus;
  logic [NS-1:0]     maskBus;
  logic              sdOut;
  logic              sdOe;

  logic [NCH*SW-1:0] mSample;
  logic [NCH*6-1:0]  mStart;
  logic [NCH-1:0]    mNa;
  logic [NS-1:0]     mMask;

  int  nRun  = 0;
  int  nFail = 0;
  bit  doneFlag = 1'b0;

  tdm_slot_tx dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameSync  (frameSync),
    .chSample   (sampleBus),
    .chStart    (startBus),
    .chNotAvail (naBus),
    .slotEnable (maskBus),
    .sdOut      (sdOut),
    .sdOe       (sdOe)
  );

  task automatic chk(string req, logic act, logic exp, string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  function automatic logic expData(int slot, int b);
    for (int c = 0; c < NCH; c++) begin
      int st;
      int pos;
      st  = int'(mStart[c*6 +: 6]);
      pos = (slot - st) * BW + b;
      if (!mNa[c] && st < NS && slot >= st && pos >= 0 && pos < SW)
        return mSample[c*SW + SW - 1 - pos];
    end
    return 1'b0;
  endfunction

  task automatic setCh(int c, int st, bit na, logic [SW-1:0] s);
    startBus[c*6 +: 6]    = 6'(st);
    naBus[c]              = na;
    sampleBus[c*SW +: SW] = s;
  endtask

  // runs nBits of a frame, comparing each bit against the model
  task automatic runFrame(string req, int nBits, bit changeMid);
    @(negedge clk);
    frameSync = 1'b1;
    mSample = sampleBus; mStart = startBus; mNa = naBus; mMask = maskBus;
    @(negedge clk);
    frameSync = 1'b0;
    if (changeMid) begin
      sampleBus = ~sampleBus;
      for (int c = 0; c < NCH; c++) startBus[c*6 +: 6] = 6'(c);
      naBus   = ~naBus;
      maskBus = ~maskBus;
    end
    for (int k = 0; k < nBits; k++) begin
      int  slot;
      int  b;
      logic eo;
      if (k > 0) @(negedge clk);
      slot = k / BW;
      b    = k % BW;
      eo   = mMask[slot];
      chk(req, sdOe, eo, $sformatf("oe slot %0d bit %0d", slot, b));
      chk(req, sdOut, eo ? expData(slot, b) : 1'b0,
          $sformatf("data slot %0d bit %0d", slot, b));
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; frameSync = 1'b0;
    sampleBus = '1; startBus = '0; naBus = '0; maskBus = '1;
    repeat (3) @(negedge clk);
    chk("R10", sdOe, 1'b0, "oe in reset");
    chk("R10", sdOut, 1'b0, "data in reset");
    rstN = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R10", sdOe, 1'b0, "oe before first sync");
      chk("R10", sdOut, 1'b0, "data before first sync");
    end

    // R2 walk of channel 0 over every start slot; R8 near the end
    for (int s = 0; s < NS; s++) begin
      setCh(0, s, 1'b0, 24'($urandom));
      for (int c = 1; c < NCH; c++) setCh(c, 48 + c, 1'b0, 24'hFFFFFF);
      maskBus = '1;
      runFrame(s >= 46 ? "R8" : "R2", FB, 1'b0);
    end

    // R1 idle after a full frame
    repeat (3) begin
      @(negedge clk);
      chk("R1", sdOe, 1'b0, "oe after frame end");
    end

    // R7 overlapping channels
    setCh(0, 4, 1'b0, 24'hA5C3F0);
    setCh(1, 5, 1'b0, 24'hFFFFFF);
    setCh(2, 4, 1'b0, 24'h0F0F0F);
    setCh(3, 6, 1'b0, 24'h123456);
    maskBus = '1;
    runFrame("R7", FB, 1'b0);

    // R3 reserved codes, R6 zero fill
    setCh(0, 48, 1'b0, 24'hFFFFFF);
    setCh(1, 63, 1'b0, 24'hFFFFFF);
    setCh(2, 55, 1'b0, 24'hFFFFFF);
    setCh(3, 10, 1'b0, 24'hFFFFFF);
    runFrame("R3", FB, 1'b0);

    // R4 missing-data flags
    setCh(0, 0, 1'b1, 24'hFFFFFF);
    setCh(1, 0, 1'b0, 24'h9ABCDE);
    setCh(2, 20, 1'b1, 24'hFFFFFF);
    setCh(3, 30, 1'b0, 24'h7E7E7E);
    runFrame("R4", FB, 1'b0);

    // R5 sparse mask, R6 enabled empty slots
    maskBus = 48'h8000_F0F0_0F01;
    runFrame("R5", FB, 1'b0);
    maskBus = 48'h0;
    runFrame("R5", FB, 1'b0);
    maskBus = 48'hFFFF_FFFF_FFFF;
    for (int c = 0; c < NCH; c++) setCh(c, 63, 1'b0, 24'hFFFFFF);
    runFrame("R6", FB, 1'b0);

    // R9 inputs changed right after sync
    setCh(0, 2, 1'b0, 24'hC0FFEE);
    setCh(1, 9, 1'b1, 24'h55AA55);
    setCh(2, 47, 1'b0, 24'hF00F00);
    setCh(3, 50, 1'b0, 24'h00FF00);
    maskBus = 48'h5555_AAAA_FFFF;
    runFrame("R9", FB, 1'b1);

    // R1 mid-frame restart
    runFrame("R1", 100, 1'b0);
    runFrame("R1", FB, 1'b0);

    // random mixes
    for (int f = 0; f < 30; f++) begin
      for (int c = 0; c < NCH; c++)
        setCh(c, int'($urandom_range(0, 63)), 1'($urandom_range(0, 3) == 0), 24'($urandom));
      maskBus = {16'($urandom), 32'($urandom)};
      runFrame("R7", FB, 1'b0);
    end

    finishRun();
  end
endmodule